// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two byte-wide bidirectional buses, called A and B. In each section it either passes the value on one bus straight through to the other, or it drives a value it captured earlier. The pins are split into separate ports. Each bus has an input vector, an output vector and a per-section output-enable. The pad ring outside the block merges them into true three-state pins. The bank holds `NUM_SECT` identical sections of `LANE_BITS` bits each. The defaults are two sections of eight bits, which gives a sixteen-bit bank. No section shares any control with another section.

Each section has two capture strobes, one for each transfer direction. Each strobe has its own storage register. The strobe toward B saves the A bus, and the strobe toward A saves the B bus. Each strobe level is sampled on the core clock, and a low-to-high change seen there loads the register. Capture goes on whatever the drive controls are set to. This lets a section record traffic while both of its ports are isolated. A per-direction source select decides whether the driven bus gets the live opposite bus or the saved word. The active-low transfer enable and the direction bit decide which bus, if any, is driven.

Top module: `xcvr_bank`

## Requirements
- R1: Each section acts only on its own lane of the buses and its own control bits. Capturing or driving in one section leaves every output of the other section as that section's own controls dictate.
- R2: A low-to-high change of `strobe_ab[s]` seen at a rising `clk` edge loads the A-bus lane present at that edge into section s's A store. The new value can be driven from the next cycle on.
- R3: A low-to-high change of `strobe_ba[s]` seen at a rising `clk` edge loads the B-bus lane present at that edge into section s's B store. The new value can be driven from the next cycle on.
- R4: Capture does not depend on `xfer_en_n`, `dir_to_b` or either select. A word captured while the section is isolated is driven later, once the section is enabled toward that side.
- R5: While `xfer_en_n[s]` is 1, both `a_oe[s]` and `b_oe[s]` are 0, and the stores change only on a capture edge.
- R6: When `xfer_en_n[s]` is 0 and `dir_to_b[s]` is 0, `a_oe[s]` is 1. The A lane then carries the live B lane if `use_reg_ba[s]` is 0, or the B store if it is 1.
- R7: When `xfer_en_n[s]` is 0 and `dir_to_b[s]` is 1, `b_oe[s]` is 1. The B lane then carries the live A lane if `use_reg_ab[s]` is 0, or the A store if it is 1.
- R8: `a_oe[s]` and `b_oe[s]` are never 1 at the same time.
- R9: The select of the direction not being driven has no effect. `use_reg_ab[s]` does not change any output while `dir_to_b[s]` is 0, and `use_reg_ba[s]` does not change any output while `dir_to_b[s]` is 1.
- R10: `rst` high at a rising `clk` edge clears both stores of every section to zero.
- R11: A strobe held high loads its store only once. A strobe that is already high when `rst` falls does not load until it has gone low and then high again.
- R12: An output lane whose enable is 0 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; strobes and bus lanes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the stores |
| xfer_en_n | input | NUM_SECT | Active-low drive enable per section |
| dir_to_b | input | NUM_SECT | 1 drives the B bus, 0 drives the A bus |
| use_reg_ab | input | NUM_SECT | Source toward B: 0 live A, 1 stored A |
| use_reg_ba | input | NUM_SECT | Source toward A: 0 live B, 1 stored B |
| strobe_ab | input | NUM_SECT | Capture strobe for the A store |
| strobe_ba | input | NUM_SECT | Capture strobe for the B store |
| a_i | input | NUM_SECT*LANE_BITS | A bus as seen at the pins |
| a_o | output | NUM_SECT*LANE_BITS | Value to place on the A bus |
| a_oe | output | NUM_SECT | Drive enable for each A lane |
| b_i | input | NUM_SECT*LANE_BITS | B bus as seen at the pins |
| b_o | output | NUM_SECT*LANE_BITS | Value to place on the B bus |
| b_oe | output | NUM_SECT | Drive enable for each B lane |

## Verification
The bench first loads each store with a value different from both live buses. It then walks every combination of enable, direction and both selects, so a swapped select or a swapped store shows up as the wrong byte on the driven lane. A design that ignores the unused select, or lets both enables rise, is caught by the same walk. Separate scenarios capture while the section is isolated, hold a strobe high while the bus changes, and keep a strobe high across a reset release. A level-sensitive or reset-blind capture would load a later byte or a stale byte in those cases. A last scenario sets opposite controls in the two sections and captures in only one, which exposes any crossing of lanes between sections.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned LANE_W   = 8;
    localparam int unsigned SECTIONS = 2;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_TO_A = 2'd1,
        DRV_TO_B = 2'd2
    } drive_e;

    typedef struct packed {
        logic en_n;
        logic dir;
        logic use_reg_ab;
        logic use_reg_ba;
    } sect_ctrl_t;

    function automatic drive_e decode_drive(input sect_ctrl_t c);
        if (c.en_n) begin
            return DRV_NONE;
        end
        return c.dir ? DRV_TO_B : DRV_TO_A;
    endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    // Loaded even during reset, so a level already high at release is no edge.
    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
            rise_o[i] |=> !rise_o[i]); // R11
    end

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d)); // R2 R3

    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R5

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
    parameter int unsigned W = 8
) (
    input  logic         enable,
    input  logic         use_reg,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] out,
    output logic         oe
);

    always_comb begin
        out = '0;
        if (enable) begin
            out = use_reg ? stored : live;
        end
    end

    assign oe = enable;

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int unsigned W = LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sect_ctrl_t   ctrl,
    input  logic         strobe_ab,
    input  logic         strobe_ba,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic         a_oe,
    output logic [W-1:0] b_o,
    output logic         b_oe
);

    localparam int unsigned STROBES = 2;

    logic [STROBES-1:0] rise;
    logic [W-1:0]       held_a;
    logic [W-1:0]       held_b;
    drive_e             drv;

    assign drv = decode_drive(ctrl);

    xcvr_rise_det #(.N(STROBES)) u_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  ({strobe_ba, strobe_ab}),
        .rise_o (rise)
    );

    xcvr_store #(.W(W)) u_store_a (
        .clk  (clk),
        .rst  (rst),
        .load (rise[0]),
        .d    (a_i),
        .q    (held_a)
    );

    xcvr_store #(.W(W)) u_store_b (
        .clk  (clk),
        .rst  (rst),
        .load (rise[1]),
        .d    (b_i),
        .q    (held_b)
    );

    xcvr_path_mux #(.W(W)) u_to_b (
        .enable  (drv == DRV_TO_B),
        .use_reg (ctrl.use_reg_ab),
        .live    (a_i),
        .stored  (held_a),
        .out     (b_o),
        .oe      (b_oe)
    );

    xcvr_path_mux #(.W(W)) u_to_a (
        .enable  (drv == DRV_TO_A),
        .use_reg (ctrl.use_reg_ba),
        .live    (b_i),
        .stored  (held_b),
        .out     (a_o),
        .oe      (a_oe)
    );

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe)); // R8

    AST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        ctrl.en_n |-> (!a_oe && !b_oe)); // R5

    AST_A_LIVE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en_n && !ctrl.dir && !ctrl.use_reg_ba) |-> (a_oe && a_o == b_i)); // R6

    AST_B_STORED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en_n && ctrl.dir && ctrl.use_reg_ab) |-> (b_oe && b_o == held_a)); // R7

    AST_A_QUIET: assert property (@(posedge clk) disable iff (rst)
        !a_oe |-> a_o == '0); // R12

    AST_B_QUIET: assert property (@(posedge clk) disable iff (rst)
        !b_oe |-> b_o == '0); // R12

endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank
    import xcvr_pkg::*;
#(
    parameter int unsigned LANE_BITS = LANE_W,
    parameter int unsigned NUM_SECT  = SECTIONS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SECT-1:0]           xfer_en_n,
    input  logic [NUM_SECT-1:0]           dir_to_b,
    input  logic [NUM_SECT-1:0]           use_reg_ab,
    input  logic [NUM_SECT-1:0]           use_reg_ba,
    input  logic [NUM_SECT-1:0]           strobe_ab,
    input  logic [NUM_SECT-1:0]           strobe_ba,
    input  logic [NUM_SECT*LANE_BITS-1:0] a_i,
    output logic [NUM_SECT*LANE_BITS-1:0] a_o,
    output logic [NUM_SECT-1:0]           a_oe,
    input  logic [NUM_SECT*LANE_BITS-1:0] b_i,
    output logic [NUM_SECT*LANE_BITS-1:0] b_o,
    output logic [NUM_SECT-1:0]           b_oe
);

    localparam int unsigned BUS_W = NUM_SECT * LANE_BITS;

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        localparam int unsigned LO = s * LANE_BITS;

        sect_ctrl_t ctrl_s;
        assign ctrl_s = {xfer_en_n[s], dir_to_b[s], use_reg_ab[s], use_reg_ba[s]};

        xcvr_section #(.W(LANE_BITS)) u_sect (
            .clk       (clk),
            .rst       (rst),
            .ctrl      (ctrl_s),
            .strobe_ab (strobe_ab[s]),
            .strobe_ba (strobe_ba[s]),
            .a_i       (a_i[LO +: LANE_BITS]),
            .b_i       (b_i[LO +: LANE_BITS]),
            .a_o       (a_o[LO +: LANE_BITS]),
            .a_oe      (a_oe[s]),
            .b_o       (b_o[LO +: LANE_BITS]),
            .b_oe      (b_oe[s])
        );
    end

    AST_BUS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $countones(a_oe & b_oe) == 0 && BUS_W == $bits(a_o)); // R8

endmodule

// File: tb/xcvr_bank_bench.sv
module xcvr_bank_bench;
    import xcvr_pkg::*;

    localparam int W = LANE_W;
    localparam int S = SECTIONS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [S*W-1:0] a_i, b_i, a_o, b_o;
    logic [S-1:0] a_oe, b_oe, en_n, dir, sab, sba, stb_ab, stb_ba;
    logic [W-1:0] a_in [S];
    logic [W-1:0] b_in [S];
    logic [W-1:0] m_sa [S];
    logic [W-1:0] m_sb [S];

    always_comb begin
        for (int s = 0; s < S; s++) begin
            a_i[s*W +: W] = a_in[s];
            b_i[s*W +: W] = b_in[s];
        end
    end

    int checks = 0;
    int errors = 0;

    xcvr_bank u_xcvr_bank (
        .clk(clk), .rst(rst), .xfer_en_n(en_n), .dir_to_b(dir),
        .use_reg_ab(sab), .use_reg_ba(sba), .strobe_ab(stb_ab), .strobe_ba(stb_ba),
        .a_i(a_i), .a_o(a_o), .a_oe(a_oe), .b_i(b_i), .b_o(b_o), .b_oe(b_oe)
    );

    task automatic chk(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_sect(input int s, input string tag);
        logic ea, eb;
        logic [W-1:0] va, vb;
        string rq;
        ea = !en_n[s] && !dir[s];
        eb = !en_n[s] && dir[s];
        va = ea ? (sba[s] ? m_sb[s] : b_in[s]) : '0;
        vb = eb ? (sab[s] ? m_sa[s] : a_in[s]) : '0;
        rq = en_n[s] ? "R5" : (dir[s] ? "R7" : "R6");
        chk(rq, {tag, " a_oe"}, W'(a_oe[s]), W'(ea));
        chk(rq, {tag, " b_oe"}, W'(b_oe[s]), W'(eb));
        chk(ea ? "R6" : "R12", {tag, " a_o"}, a_o[s*W +: W], va);
        chk(eb ? "R7" : "R12", {tag, " b_o"}, b_o[s*W +: W], vb);
        chk("R8", {tag, " both enables"}, W'(a_oe[s] & b_oe[s]), '0);
    endtask

    task automatic set_ctrl(input int s, input logic e, input logic d,
                            input logic ab, input logic ba);
        en_n[s] = e; dir[s] = d; sab[s] = ab; sba[s] = ba;
    endtask

    task automatic pulse(input int s, input bit to_b);
        @(negedge clk);
        if (to_b) begin stb_ab[s] = 1'b1; m_sa[s] = a_in[s]; end
        else begin stb_ba[s] = 1'b1; m_sb[s] = b_in[s]; end
        @(negedge clk);
        stb_ab[s] = 1'b0; stb_ba[s] = 1'b0;
        #1;
    endtask

    task automatic t_reset_state();
        for (int s = 0; s < S; s++) check_sect(s, "reset isolated");
        @(negedge clk);
        for (int s = 0; s < S; s++) set_ctrl(s, 1'b0, 1'b0, 1'b0, 1'b1);
        #1;
        for (int s = 0; s < S; s++) chk("R10", "B store after reset", a_o[s*W +: W], '0);
        @(negedge clk);
        for (int s = 0; s < S; s++) set_ctrl(s, 1'b0, 1'b1, 1'b1, 1'b0);
        #1;
        for (int s = 0; s < S; s++) chk("R10", "A store after reset", b_o[s*W +: W], '0);
    endtask

    task automatic t_capture_isolated();
        @(negedge clk);
        set_ctrl(0, 1'b1, 1'b0, 1'b1, 1'b1);
        a_in[0] = 8'h3C; b_in[0] = 8'hC5;
        pulse(0, 1'b1);
        pulse(0, 1'b0);
        check_sect(0, "isolated during capture");
        @(negedge clk);
        a_in[0] = 8'h81; b_in[0] = 8'h18;
        set_ctrl(0, 1'b0, 1'b1, 1'b1, 1'b0);
        #1;
        chk("R4", "A word captured while isolated", b_o[7:0], 8'h3C);
        chk("R2", "A store value", b_o[7:0], m_sa[0]);
        @(negedge clk);
        set_ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
        #1;
        chk("R3", "B store value", a_o[7:0], 8'hC5);
    endtask

    task automatic t_sweep(input logic [W-1:0] pa, input logic [W-1:0] pb);
        for (int s = 0; s < S; s++) begin
            @(negedge clk);
            a_in[s] = pa ^ W'(s * 8'h11);
            b_in[s] = pb ^ W'(s * 8'h22);
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                set_ctrl(s, c[3], c[2], c[1], c[0]);
                #1;
                check_sect(s, "sweep");
            end
        end
    endtask

    task automatic t_unused_select();
        @(negedge clk);
        set_ctrl(1, 1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        begin
            logic [W-1:0] ref_a;
            ref_a = a_o[W +: W];
            @(negedge clk); sab[1] = 1'b1; #1;
            chk("R9", "select toward B while driving A", a_o[W +: W], ref_a);
            chk("R9", "B lane stays quiet", b_o[W +: W], '0);
        end
        @(negedge clk);
        set_ctrl(1, 1'b0, 1'b1, 1'b0, 1'b0);
        #1;
        begin
            logic [W-1:0] ref_b;
            ref_b = b_o[W +: W];
            @(negedge clk); sba[1] = 1'b1; #1;
            chk("R9", "select toward A while driving B", b_o[W +: W], ref_b);
            chk("R9", "A lane stays quiet", a_o[W +: W], '0);
        end
    endtask

    task automatic t_level_held();
        @(negedge clk);
        set_ctrl(1, 1'b0, 1'b1, 1'b1, 1'b0);
        a_in[1] = 8'h11;
        stb_ab[1] = 1'b1; m_sa[1] = 8'h11;
        @(negedge clk);
        a_in[1] = 8'h22;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R11", "held strobe loads once", b_o[W +: W], 8'h11);
        @(negedge clk);
        stb_ab[1] = 1'b0;
        #1;
        chk("R2", "store after strobe drop", b_o[W +: W], m_sa[1]);
    endtask

    task automatic t_independent();
        @(negedge clk);
        a_in[0] = 8'h5A; a_in[1] = 8'hA7; b_in[0] = 8'h0F; b_in[1] = 8'hF0;
        set_ctrl(0, 1'b0, 1'b1, 1'b1, 1'b0);
        set_ctrl(1, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse(0, 1'b1);
        chk("R1", "section 0 drives new A store", b_o[7:0], 8'h5A);
        chk("R1", "section 1 keeps its B store", a_o[W +: W], m_sb[1]);
        chk("R1", "section 1 A enable", W'(a_oe[1]), W'(1'b1));
        chk("R1", "section 0 A enable", W'(a_oe[0]), W'(1'b0));
        check_sect(0, "independent s0");
        check_sect(1, "independent s1");
    endtask

    task automatic t_reset_with_strobes();
        @(negedge clk);
        a_in[0] = 8'h77; b_in[0] = 8'h99;
        stb_ab[0] = 1'b1; stb_ba[0] = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_sa[0] = '0; m_sb[0] = '0; m_sa[1] = '0; m_sb[1] = '0;
        @(negedge clk);
        @(negedge clk);
        set_ctrl(0, 1'b0, 1'b1, 1'b1, 1'b0);
        set_ctrl(1, 1'b0, 1'b0, 1'b0, 1'b1);
        #1;
        chk("R11", "no load from strobe high at release", b_o[7:0], 8'h00);
        chk("R10", "section 1 B store cleared", a_o[W +: W], 8'h00);
        @(negedge clk);
        set_ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
        #1;
        chk("R10", "section 0 B store cleared", a_o[7:0], 8'h00);
        @(negedge clk);
        stb_ab[0] = 1'b0; stb_ba[0] = 1'b0;
        pulse(0, 1'b0);
        chk("R3", "fresh edge after reset loads", a_o[7:0], 8'h99);
    endtask

    initial begin
        en_n = '1; dir = '0; sab = '0; sba = '0; stb_ab = '0; stb_ba = '0;
        for (int s = 0; s < S; s++) begin
            a_in[s] = '0; b_in[s] = '0; m_sa[s] = '0; m_sb[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset_state();
        t_capture_isolated();
        for (int s = 0; s < S; s++) begin
            @(negedge clk);
            a_in[s] = 8'hE1 + W'(s); b_in[s] = 8'h2D + W'(s);
            pulse(s, 1'b1);
            pulse(s, 1'b0);
        end
        t_sweep(8'hA5, 8'h3C);
        t_sweep(8'h00, 8'hFF);
        t_sweep(8'h96, 8'h69);
        t_unused_select();
        t_level_held();
        t_independent();
        t_reset_with_strobes();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog all-requirements actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule